// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

This block is the combinational arithmetic-logic unit for the execute stage of a simple load/store processor. It takes two operands of `WIDTH` bits (32 by default) and a 3-bit operation code. It returns the selected result together with a zero flag, a carry flag and a signed overflow flag, all within the same cycle. The operations are bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than.

The datapath is a chain of identical one-bit slices. Each slice forms the AND, the OR and a full-adder sum of its operand bits. Subtraction reuses the same chain: the b operand is inverted and the carry into bit 0 is forced high. The less-than result is taken from that subtraction, with the overflow correction applied, so the comparison stays correct across the whole signed range. The block raises no trap of its own. The surrounding pipeline decides what to do with the overflow flag.

Top module: `alu32_core`

## Requirements
- R1: Code 3'b000 drives `res_o` with the bitwise AND of `a_i` and `b_i`.
- R2: Code 3'b001 drives `res_o` with the bitwise OR of `a_i` and `b_i`.
- R3: Code 3'b010 drives `res_o` with `(a_i + b_i) mod 2^WIDTH`. `carry_o` is the carry out of the top bit of that sum.
- R4: Code 3'b110 drives `res_o` with `(a_i - b_i) mod 2^WIDTH`, formed as `a_i + ~b_i + 1`. `carry_o` is the carry out of the top bit, which is 1 exactly when `a_i >= b_i` as unsigned numbers.
- R5: Code 3'b111 drives `res_o` with 1 in bit 0 and zeros in every other bit when `a_i < b_i` as two's-complement numbers, and all zeros otherwise. This holds even when `a_i - b_i` overflows.
- R6: `zero_o` is 1 exactly when every bit of `res_o` is 0, for every code.
- R7: For code 3'b010, `ovf_o` is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R8: For code 3'b110, `ovf_o` is 1 exactly when the operands' sign bits differ and the difference's sign bit differs from the sign bit of `a_i`.
- R9: For codes 3'b000, 3'b001 and 3'b111, `ovf_o` and `carry_o` are 0.
- R10: Codes 3'b011, 3'b100 and 3'b101 give `res_o` = 0, `carry_o` = 0 and `ovf_o` = 0 (so `zero_o` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (the subtrahend for code 110) |
| op_i | input | 3 | Operation code |
| res_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when the result is all zeros |
| carry_o | output | 1 | Carry out of the top adder bit, for add and subtract only |
| ovf_o | output | 1 | Signed overflow, for add and subtract only |

## Verification
Every output is combinational, so each result is due in the same cycle its operands and code are applied, with no register in the path. The bench changes the operands and the code one time unit after a rising edge. It compares all four outputs at the following falling edge, half a period later, so the whole carry chain has settled and no edge race can occur. A 4-bit instance is swept over every operand pair and every code. The 32-bit instance is driven with sign-boundary operand pairs and a pseudo-random stream, and is checked against an arithmetic model in the bench.

// File: rtl/alu32_pkg.sv
// Package alu32_pkg
// Shared operation codes for the arithmetic-logic unit.
// Assumes: the code field is 3 bits wide. Codes not listed here are unused.
package alu32_pkg;

    typedef logic [2:0] alu_code_t;

    localparam alu_code_t CODE_AND = 3'b000;
    localparam alu_code_t CODE_OR  = 3'b001;
    localparam alu_code_t CODE_ADD = 3'b010;
    localparam alu_code_t CODE_SUB = 3'b110;
    localparam alu_code_t CODE_SLT = 3'b111;

endpackage

// File: rtl/alu32_slice.sv
// Module alu32_slice
// One bit of the datapath: AND, OR and a full-adder sum with a
// selectable inversion of the b bit.
// Assumes: the inversion applies to the adder path only. The logic
// outputs always see the true b bit.
module alu32_slice (
    input  logic a_i,
    input  logic b_i,
    input  logic inv_i,
    input  logic cin_i,
    output logic and_o,
    output logic or_o,
    output logic sum_o,
    output logic cout_o
);

    logic b_eff;

    // Logic outputs and the full adder on the possibly inverted b bit.
    always_comb begin
        b_eff  = b_i ^ inv_i;
        and_o  = a_i & b_i;
        or_o   = a_i | b_i;
        sum_o  = a_i ^ b_eff ^ cin_i;
        cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    end

endmodule

// File: rtl/alu32_chain.sv
// Module alu32_chain
// WIDTH one-bit slices with a rippled carry. When inv_i is high the b
// operand is inverted and the carry into bit 0 is 1, which gives a - b.
// Assumes: WIDTH >= 2.
module alu32_chain #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] carry;

    // The carry into bit 0 doubles as the +1 of the two's-complement negation.
    always_comb carry[0] = inv_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        alu32_slice u_slice (
            .a_i    (a_i[k]),
            .b_i    (b_i[k]),
            .inv_i  (inv_i),
            .cin_i  (carry[k]),
            .and_o  (and_o[k]),
            .or_o   (or_o[k]),
            .sum_o  (sum_o[k]),
            .cout_o (carry[k+1])
        );
    end

    // The carry out of the top bit.
    always_comb cout_o = carry[WIDTH];

endmodule

// File: rtl/alu32_select.sv
// Module alu32_select
// Picks the result for the operation code and forms the zero, carry
// and signed overflow flags.
// Assumes: sum_i already holds a + b for add, or a + ~b + 1 for
// subtract and set-on-less-than.
module alu32_select
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_code_t        op_i,
    input  logic             a_msb_i,
    input  logic             b_msb_i,
    input  logic [WIDTH-1:0] and_i,
    input  logic [WIDTH-1:0] or_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             cout_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic add_ovf;
    logic sub_ovf;
    logic lt_bit;

    // Overflow from the sign rules, plus the overflow-corrected less-than bit.
    always_comb begin
        add_ovf = (a_msb_i == b_msb_i) && (sum_i[MSB] != a_msb_i);
        sub_ovf = (a_msb_i != b_msb_i) && (sum_i[MSB] != a_msb_i);
        lt_bit  = sum_i[MSB] ^ sub_ovf;
    end

    // Output mux. Unused codes give zero with both flags low.
    always_comb begin
        res_o   = '0;
        carry_o = 1'b0;
        ovf_o   = 1'b0;
        case (op_i)
            CODE_AND: res_o = and_i;
            CODE_OR:  res_o = or_i;
            CODE_ADD: begin
                res_o   = sum_i;
                carry_o = cout_i;
                ovf_o   = add_ovf;
            end
            CODE_SUB: begin
                res_o   = sum_i;
                carry_o = cout_i;
                ovf_o   = sub_ovf;
            end
            CODE_SLT: res_o = {{(WIDTH-1){1'b0}}, lt_bit};
            default:  res_o = '0;
        endcase
    end

    // The zero flag looks at the final result.
    always_comb zero_o = ~|res_o;

endmodule

// File: rtl/alu32_core.sv
// Module alu32_core
// Combinational arithmetic-logic unit: AND, OR, add, subtract and
// signed set-on-less-than, with zero, carry and overflow flags.
// Assumes: the caller decides what a raised overflow means. WIDTH >= 2.
module alu32_core
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic             inv_b;
    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] or_v;
    logic [WIDTH-1:0] sum_v;
    logic             cout_v;

    // Bit 2 of the code selects the a + ~b + 1 form (subtract and compare).
    always_comb inv_b = op_i[2];

    alu32_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i    (a_i),
        .b_i    (b_i),
        .inv_i  (inv_b),
        .and_o  (and_v),
        .or_o   (or_v),
        .sum_o  (sum_v),
        .cout_o (cout_v)
    );

    alu32_select #(.WIDTH(WIDTH)) u_select (
        .op_i    (op_i),
        .a_msb_i (a_i[MSB]),
        .b_msb_i (b_i[MSB]),
        .and_i   (and_v),
        .or_i    (or_v),
        .sum_i   (sum_v),
        .cout_i  (cout_v),
        .res_o   (res_o),
        .zero_o  (zero_o),
        .carry_o (carry_o),
        .ovf_o   (ovf_o)
    );

    // Port-level checks on the settled outputs.
    always_comb begin
        if (op_i == CODE_AND)
            a_r1_and_within_a: assert ((res_o & ~a_i) == '0)
                else $error("R1: AND result has a bit that a_i lacks");
        if (op_i == CODE_OR)
            a_r2_or_covers_a: assert ((res_o & a_i) == a_i)
                else $error("R2: OR result drops a bit of a_i");
        if (op_i == CODE_SLT)
            a_r5_slt_lsb_only: assert (res_o[MSB:1] == '0)
                else $error("R5: set-on-less-than sets an upper bit");
        if (op_i == CODE_ADD && a_i[MSB] != b_i[MSB])
            a_r7_no_overflow: assert (!ovf_o)
                else $error("R7: overflow on mixed-sign add");
        if (op_i == CODE_SUB && a_i[MSB] == b_i[MSB])
            a_r8_no_overflow: assert (!ovf_o)
                else $error("R8: overflow on same-sign subtract");
        if (op_i == CODE_AND || op_i == CODE_OR || op_i == CODE_SLT)
            a_r9_no_flags: assert (!ovf_o && !carry_o)
                else $error("R9: flag raised on logic or compare");
        if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
            a_r10_unused_quiet: assert (res_o == '0 && !ovf_o && !carry_o && zero_o)
                else $error("R10: unused code gives a nonzero output");
    end

endmodule

// File: tb/alu32_core_bench.sv
module alu32_core_bench;

    localparam int WB = 32;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 8 ns period

    logic [WB-1:0] a_b, b_b, r_b;
    logic [2:0]    op_b;
    logic          z_b, c_b, v_b;
    logic [WS-1:0] a_s, b_s, r_s;
    logic [2:0]    op_s;
    logic          z_s, c_s, v_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    alu32_core #(.WIDTH(WB)) u_alu32_core (
        .a_i(a_b), .b_i(b_b), .op_i(op_b),
        .res_o(r_b), .zero_o(z_b), .carry_o(c_b), .ovf_o(v_b)
    );

    alu32_core #(.WIDTH(WS)) u_alu32_core_w4 (
        .a_i(a_s), .b_i(b_s), .op_i(op_s),
        .res_o(r_s), .zero_o(z_s), .carry_o(c_s), .ovf_o(v_s)
    );

    // Arithmetic reference model built directly from the requirements.
    function automatic void model(input int w, input longint unsigned a, input longint unsigned b,
                                  input logic [2:0] op, output longint unsigned r,
                                  output logic z, output logic c, output logic v);
        longint unsigned mask = (64'd1 << w) - 1;
        longint sa = ((a >> (w-1)) & 1) != 0 ? longint'(a) - longint'(64'd1 << w) : longint'(a);
        longint sb = ((b >> (w-1)) & 1) != 0 ? longint'(b) - longint'(64'd1 << w) : longint'(b);
        longint hi = longint'(64'd1 << (w-1)) - 1;
        longint lo = -longint'(64'd1 << (w-1));
        longint unsigned full;
        r = 0; c = 1'b0; v = 1'b0;
        case (op)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: begin
                full = a + b;
                r = full & mask;
                c = ((full >> w) & 1) != 0;
                v = (sa + sb > hi) || (sa + sb < lo);
            end
            3'b110: begin
                full = a + ((~b) & mask) + 1;
                r = full & mask;
                c = ((full >> w) & 1) != 0;
                v = (sa - sb > hi) || (sa - sb < lo);
            end
            3'b111: r = (sa < sb) ? 1 : 0;
            default: r = 0;
        endcase
        z = (r == 0);
    endfunction

    function automatic string res_tag(input logic [2:0] op);
        case (op)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b110: return "R4";
            3'b111: return "R5";
            default: return "R10";
        endcase
    endfunction

    function automatic string flag_tag(input logic [2:0] op, input bit is_ovf);
        case (op)
            3'b010: return is_ovf ? "R7" : "R3";
            3'b110: return is_ovf ? "R8" : "R4";
            3'b000, 3'b001, 3'b111: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare(input int w, input longint unsigned a, input longint unsigned b,
                           input logic [2:0] op, input longint unsigned gr,
                           input logic gz, input logic gc, input logic gv);
        longint unsigned er;
        logic ez, ec, ev;
        model(w, a, b, op, er, ez, ec, ev);
        n_chk += 4;
        if (gr != er) begin
            n_bad++;
            $display("FAIL %s w=%0d op=%b a=%h b=%h res actual=%h expected=%h", res_tag(op), w, op, a, b, gr, er);
        end
        if (gz != ez) begin
            n_bad++;
            $display("FAIL R6 w=%0d op=%b a=%h b=%h zero actual=%0d expected=%0d", w, op, a, b, gz, ez);
        end
        if (gc != ec) begin
            n_bad++;
            $display("FAIL %s w=%0d op=%b a=%h b=%h carry actual=%0d expected=%0d", flag_tag(op, 1'b0), w, op, a, b, gc, ec);
        end
        if (gv != ev) begin
            n_bad++;
            $display("FAIL %s w=%0d op=%b a=%h b=%h ovf actual=%0d expected=%0d", flag_tag(op, 1'b1), w, op, a, b, gv, ev);
        end
    endtask

    // Drive just after a rising edge; results are due in the same cycle, so compare at the falling edge.
    task automatic run_big(input logic [WB-1:0] a, input logic [WB-1:0] b, input logic [2:0] op);
        @(posedge clk); #1;
        a_b = a; b_b = b; op_b = op;
        @(negedge clk);
        compare(WB, longint'(a), longint'(b), op, longint'(r_b), z_b, c_b, v_b);
    endtask

    task automatic run_small(input logic [WS-1:0] a, input logic [WS-1:0] b, input logic [2:0] op);
        @(posedge clk); #1;
        a_s = a; b_s = b; op_s = op;
        @(negedge clk);
        compare(WS, longint'(a), longint'(b), op, longint'(r_s), z_s, c_s, v_s);
    endtask

    function automatic logic [WB-1:0] corner(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h8000_0001;
            6: return 32'hFFFF_FFFE;
            7: return 32'h0000_0002;
            8: return 32'hFFFF_FFBA;
            default: return 32'h1234_5678;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [WB-1:0] x;
        a_b = '0; b_b = '0; op_b = 3'b000;
        a_s = '0; b_s = '0; op_s = 3'b000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero operands with the AND code, so the result is zero (R1, R6).
        @(negedge clk);
        compare(WB, 0, 0, 3'b000, longint'(r_b), z_b, c_b, v_b);
        compare(WS, 0, 0, 3'b000, longint'(r_s), z_s, c_s, v_s);

        // R1..R10 exhaustively on the 4-bit instance: every pair, every code.
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    run_small(WS'(i), WS'(j), 3'(o));

        // Sign-boundary pairs on the 32-bit instance: R5 and R7, R8 overflow edges.
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run_big(corner(i), corner(j), 3'(o));

        // Equality by subtraction: zero flag high for equal operands (R6).
        run_big(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);

        // Pseudo-random stream over all codes (R1..R10).
        x = 32'h1ACE_B00C;
        for (int n = 0; n < 1200; n++) begin
            logic [WB-1:0] ra, rb;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            ra = x;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            rb = x;
            run_big(ra, rb, 3'(n % 8));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule